// File: doc/BRIEF.md
# Power Domain State Sequencer

This block runs the power state of one power domain. Software-visible control fields reach it as plain ports: a target state, a logic-keep select and a deeper-change request. Hardware readiness signals also come in as ports: voltage present, per-clock-domain idle and wake flags, clock generator quiet, input clocks gated, a clock request and a controller service request. From these the block moves the domain between four states. Going down, it takes one level per step and needs every idle condition to hold. Going up, it returns to the full-on state in a single step once the voltage is present and any wake source is asserted.

Each change is a transaction. A transition flag rises, a fixed settle interval passes, and then the new state is committed. In the same cycle as the commit, the previous state is recorded and the logic power and logic retention enables are updated. After a descent has stopped in a low-power state, the domain goes deeper only if a deeper-change request is pulsed. It does not have to wake up first.

Top module: `pds_ctrl`

## Requirements
- R1: After reset, the current state is ON-ACTIVE (11), the last-state field is 11, the transition flag is low, logic power is enabled and logic retention is disabled.
- R2: State codes are 00 OFF, 01 RETENTION, 10 ON-INACTIVE, 11 ON-ACTIVE. The domain never descends below the target state, and it stays unchanged when the target is at or above the current state.
- R3: A descent started from ON-ACTIVE moves exactly one code level per step. It continues step after step, without further requests, until it reaches the target, as long as the sleep condition holds.
- R4: A step down starts only when all clock-domain idle flags are high, the clock generator is quiet, its input clocks are gated and there is no service request. If any one of these fails, the state stays unchanged.
- R5: Wake-up from any of 00, 01 or 10 commits 11 in one transition, with no intermediate state.
- R6: A wake transition starts only when voltage is on AND at least one of these holds: a clock-domain wake flag, the clock request, or the service request. Wake sources without voltage have no effect.
- R7: Once a descent has stopped in a low-power state, lowering the target alone does not move the domain. A deeper-change request, together with the sleep condition, starts the next step down.
- R8: The transition flag is high for exactly SETTLE cycles per transition, and the current state changes only at the end of that interval.
- R9: At each commit, the last-state field takes the state that was current just before the commit.
- R10: Logic power is enabled in 10 and 11. In 01 with logic-keep set, logic retention is enabled and the logic status is ON. In 01 without logic-keep, and in 00, both enables are off and the logic status is OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_state | input | 2 | Programmed target state |
| logic_keep | input | 1 | Keep logic in retention when entering 01 |
| deep_req | input | 1 | Deeper-change request from a settled low state |
| volt_on | input | 1 | Voltage domain is powered |
| cd_idle | input | NCD | Per clock-domain idle flags |
| cd_wake | input | NCD | Per clock-domain wake flags |
| clkgen_quiet | input | 1 | Clock generation is quiet |
| clkin_gated | input | 1 | Clock generator input clocks are gated |
| clk_req | input | 1 | Request for clock generation or distribution |
| svc_req | input | 1 | Controller service request |
| cur_state | output | 2 | Current power state |
| last_state | output | 2 | State current before the latest commit |
| busy | output | 1 | Transition in progress |
| logic_on | output | 1 | Logic status: 1 ON, 0 OFF |
| logic_pwr_en | output | 1 | Logic power enable |
| logic_ret_en | output | 1 | Logic retention enable |

## Verification
On every cycle, the assertions check four things. Wake and sleep starts happen only under their gating conditions. A commit either steps down one level or lands on 11. The last-state field follows each commit. The transition flag never outlasts the settle interval. Other behaviours can only be shown by the bench's scenarios: that an automatic descent halts at the target, that a settled low state needs a deeper-change request, that wake sources are ignored while voltage is off, and the exact ordered list of committed states with their logic enables.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [1:0] {
    PS_OFF  = 2'b00,
    PS_RET  = 2'b01,
    PS_INA  = 2'b10,
    PS_ACT  = 2'b11
  } pstate_t;

  // one level down; never below OFF
  function automatic logic [1:0] step_down(input logic [1:0] s);
    return (s == 2'b00) ? 2'b00 : s - 2'd1;
  endfunction

  // logic power is up in both ON states
  function automatic logic pwr_for(input logic [1:0] s);
    return s[1];
  endfunction

  // retention only in RETENTION with the keep select
  function automatic logic ret_for(input logic [1:0] s, input logic keep);
    return (s == 2'b01) && keep;
  endfunction

endpackage

// File: rtl/pds_cond.sv
module pds_cond #(
  parameter int NCD = 4
) (
  input  logic [NCD-1:0] cd_idle,
  input  logic [NCD-1:0] cd_wake,
  input  logic           volt_on,
  input  logic           clkgen_quiet,
  input  logic           clkin_gated,
  input  logic           clk_req,
  input  logic           svc_req,
  output logic           sleep_ok,
  output logic           wake_ok
);

  logic all_idle;
  logic any_wake;

  assign all_idle = &cd_idle;
  assign any_wake = (|cd_wake) || clk_req || svc_req;

  assign sleep_ok = all_idle && clkgen_quiet && clkin_gated && !svc_req;
  assign wake_ok  = volt_on && any_wake;

endmodule

// File: rtl/pds_plan.sv
module pds_plan
  import pds_pkg::*;
(
  input  logic       busy,
  input  logic [1:0] cur,
  input  logic [1:0] tgt,
  input  logic       run,
  input  logic       deep_req,
  input  logic       sleep_ok,
  input  logic       wake_ok,
  output logic       go_wake,
  output logic       go_down,
  output logic [1:0] dest
);

  logic below_act;
  logic may_desc;

  assign below_act = (cur != PS_ACT);
  // from full-on a descent may begin; lower down it needs a live run or a request
  assign may_desc  = (cur == PS_ACT) || run || deep_req;

  always_comb begin
    go_wake = 1'b0;
    go_down = 1'b0;
    dest    = cur;
    if (!busy) begin
      if (below_act && wake_ok) begin
        go_wake = 1'b1;
        dest    = PS_ACT;
      end else if ((tgt < cur) && sleep_ok && may_desc) begin
        go_down = 1'b1;
        dest    = step_down(cur);
      end
    end
  end

endmodule

// File: rtl/pds_settle.sv
module pds_settle #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LOAD = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= LOAD;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter int NCD    = 4,
  parameter int SETTLE = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     tgt_state,
  input  logic           logic_keep,
  input  logic           deep_req,
  input  logic           volt_on,
  input  logic [NCD-1:0] cd_idle,
  input  logic [NCD-1:0] cd_wake,
  input  logic           clkgen_quiet,
  input  logic           clkin_gated,
  input  logic           clk_req,
  input  logic           svc_req,
  output logic [1:0]     cur_state,
  output logic [1:0]     last_state,
  output logic           busy,
  output logic           logic_on,
  output logic           logic_pwr_en,
  output logic           logic_ret_en
);

  logic       sleep_ok, wake_ok;
  logic       start_wake, start_down, start_any;
  logic       commit_evt;
  logic [1:0] dest;
  logic [1:0] nxt_q;
  logic       keep_q;
  logic       run_q;

  assign start_any = start_wake || start_down;

  pds_cond #(.NCD(NCD)) u_cond (
    .cd_idle      (cd_idle),
    .cd_wake      (cd_wake),
    .volt_on      (volt_on),
    .clkgen_quiet (clkgen_quiet),
    .clkin_gated  (clkin_gated),
    .clk_req      (clk_req),
    .svc_req      (svc_req),
    .sleep_ok     (sleep_ok),
    .wake_ok      (wake_ok)
  );

  pds_plan u_plan (
    .busy     (busy),
    .cur      (cur_state),
    .tgt      (tgt_state),
    .run      (run_q),
    .deep_req (deep_req),
    .sleep_ok (sleep_ok),
    .wake_ok  (wake_ok),
    .go_wake  (start_wake),
    .go_down  (start_down),
    .dest     (dest)
  );

  pds_settle #(.SETTLE(SETTLE)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_any),
    .busy  (busy),
    .done  (commit_evt)
  );

  // latch the destination and keep select when a transition is launched
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q  <= PS_ACT;
      keep_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (!busy) begin
      run_q <= start_down;
      if (start_any) begin
        nxt_q  <= dest;
        keep_q <= logic_keep;
      end
    end
  end

  // commit of state, history and logic enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_state    <= PS_ACT;
      last_state   <= PS_ACT;
      logic_pwr_en <= 1'b1;
      logic_ret_en <= 1'b0;
    end else if (commit_evt) begin
      cur_state    <= nxt_q;
      last_state   <= cur_state;
      logic_pwr_en <= pwr_for(nxt_q);
      logic_ret_en <= ret_for(nxt_q, keep_q);
    end
  end

  assign logic_on = logic_pwr_en || logic_ret_en;

endmodule

// File: rtl/pds_ctrl_chk.sv
module pds_ctrl_chk #(
  parameter int NCD    = 4,
  parameter int SETTLE = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     cur_state,
  input logic [1:0]     last_state,
  input logic           busy,
  input logic           logic_pwr_en,
  input logic           logic_ret_en,
  input logic           start_wake,
  input logic           start_down,
  input logic           commit_evt,
  input logic           volt_on,
  input logic [NCD-1:0] cd_idle,
  input logic [NCD-1:0] cd_wake,
  input logic           clkgen_quiet,
  input logic           clkin_gated,
  input logic           clk_req,
  input logic           svc_req
);

  localparam int BW = $clog2(SETTLE + 2);
  logic [BW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R8
  stable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cur_state));

  // R8
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= BW'(SETTLE));

  // R3
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (cur_state == 2'b11) || (2'(cur_state + 2'd1) == $past(cur_state)));

  // R9
  last_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> last_state == $past(cur_state));

  // R6
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_wake |-> volt_on && ((|cd_wake) || clk_req || svc_req));

  // R4
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_down |-> (&cd_idle) && clkgen_quiet && clkin_gated && !svc_req);

  // R10
  ret_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    logic_ret_en |-> (cur_state == 2'b01) && !logic_pwr_en);

  // R5
  wake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_wake && start_down));

endmodule

bind pds_ctrl pds_ctrl_chk #(.NCD(NCD), .SETTLE(SETTLE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cur_state    (cur_state),
  .last_state   (last_state),
  .busy         (busy),
  .logic_pwr_en (logic_pwr_en),
  .logic_ret_en (logic_ret_en),
  .start_wake   (start_wake),
  .start_down   (start_down),
  .commit_evt   (commit_evt),
  .volt_on      (volt_on),
  .cd_idle      (cd_idle),
  .cd_wake      (cd_wake),
  .clkgen_quiet (clkgen_quiet),
  .clkin_gated  (clkin_gated),
  .clk_req      (clk_req),
  .svc_req      (svc_req)
);

// File: tb/pds_ctrl_tb.sv
module pds_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCD        = 4;
  localparam int SETTLE     = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     tgt_state = 2'b11;
  logic           logic_keep = 1'b0;
  logic           deep_req = 1'b0;
  logic           volt_on = 1'b1;
  logic [NCD-1:0] cd_idle = '1;
  logic [NCD-1:0] cd_wake = '0;
  logic           clkgen_quiet = 1'b1;
  logic           clkin_gated = 1'b1;
  logic           clk_req = 1'b0;
  logic           svc_req = 1'b0;
  logic [1:0]     cur_state, last_state;
  logic           busy, logic_on, logic_pwr_en, logic_ret_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  pds_ctrl #(.NCD(NCD), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tgt_state(tgt_state), .logic_keep(logic_keep),
    .deep_req(deep_req), .volt_on(volt_on), .cd_idle(cd_idle), .cd_wake(cd_wake),
    .clkgen_quiet(clkgen_quiet), .clkin_gated(clkin_gated), .clk_req(clk_req),
    .svc_req(svc_req), .cur_state(cur_state), .last_state(last_state), .busy(busy),
    .logic_on(logic_on), .logic_pwr_en(logic_pwr_en), .logic_ret_en(logic_ret_en)
  );

  typedef struct packed {
    logic [1:0] st;
    logic [1:0] last;
    logic       pwr;
    logic       ret;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    ended  = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver side: expected commit, logic enables restated from R10
  task automatic expect_commit(input logic [1:0] st, input logic [1:0] last, input logic keep);
    item_t it;
    it.st   = st;
    it.last = last;
    it.pwr  = (st == 2'b11) || (st == 2'b10);
    it.ret  = (st == 2'b01) && keep;
    exp_q.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: each end of a transition pops one expected item
  logic prev_busy = 1'b0;
  int   blen = 0;
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (busy) blen++;
      if (prev_busy && !busy) begin
        chk("R8 busy length", blen, SETTLE);
        if (exp_q.size() == 0) begin
          chk("R5/R3 unexpected commit state", int'(cur_state), -1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk("R3/R5 committed state", int'(cur_state), int'(it.st));
          chk("R9 last state", int'(last_state), int'(it.last));
          chk("R10 logic power", int'(logic_pwr_en), int'(it.pwr));
          chk("R10 logic retention", int'(logic_ret_en), int'(it.ret));
          chk("R10 logic status", int'(logic_on), int'(it.pwr || it.ret));
        end
      end
      if (!busy) blen = 0;
      prev_busy = busy;
    end
  end

  task automatic finish_run();
    ended = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 cur_state", int'(cur_state), 3);
    chk("R1 last_state", int'(last_state), 3);
    chk("R1 busy", int'(busy), 0);
    chk("R1 logic_pwr_en", int'(logic_pwr_en), 1);
    chk("R1 logic_ret_en", int'(logic_ret_en), 0);

    // R2 target equal to current: nothing moves
    tick(20);
    chk("R2 hold at target", int'(cur_state), 3);
    chk("R8 idle flag", int'(busy), 0);

    // R3 automatic descent to RETENTION with logic kept
    logic_keep = 1'b1;
    tgt_state  = 2'b01;
    expect_commit(2'b10, 2'b11, 1'b1);
    expect_commit(2'b01, 2'b10, 1'b1);
    tick(3 * (SETTLE + 2) + 10);
    chk("R2 stop at target", int'(cur_state), 1);
    chk("R10 retained logic on", int'(logic_on), 1);

    // R7 lower target alone does nothing from settled low state
    tgt_state = 2'b00;
    tick(20);
    chk("R7 no move without request", int'(cur_state), 1);
    deep_req = 1'b1;
    expect_commit(2'b00, 2'b01, 1'b1);
    tick(1);
    deep_req = 1'b0;
    tick(SETTLE + 10);
    chk("R7 deeper reached", int'(cur_state), 0);
    chk("R10 OFF logic status", int'(logic_on), 0);

    // R6 wake source without voltage is ignored
    tgt_state = 2'b11;
    volt_on   = 1'b0;
    cd_wake   = 4'b0100;
    tick(20);
    chk("R6 no wake without voltage", int'(cur_state), 0);
    chk("R6 no transition", int'(busy), 0);
    // R5 direct wake from OFF
    expect_commit(2'b11, 2'b00, 1'b1);
    volt_on = 1'b1;
    tick(SETTLE + 10);
    cd_wake = '0;
    chk("R5 woke to active", int'(cur_state), 3);

    // R4 each sleep condition blocks the first step
    logic_keep = 1'b0;
    cd_idle    = 4'b1110;
    tgt_state  = 2'b00;
    tick(20);
    chk("R4 clock domain busy blocks", int'(cur_state), 3);
    cd_idle = '1;
    svc_req = 1'b1;
    tick(20);
    chk("R4 service request blocks", int'(cur_state), 3);
    svc_req     = 1'b0;
    clkin_gated = 1'b0;
    tick(20);
    chk("R4 ungated input clock blocks", int'(cur_state), 3);
    clkin_gated  = 1'b1;
    clkgen_quiet = 1'b0;
    tick(20);
    chk("R4 clock generator active blocks", int'(cur_state), 3);

    // R3 full descent to OFF, logic lost in RETENTION (R10)
    expect_commit(2'b10, 2'b11, 1'b0);
    expect_commit(2'b01, 2'b10, 1'b0);
    expect_commit(2'b00, 2'b01, 1'b0);
    clkgen_quiet = 1'b1;
    tick(4 * (SETTLE + 2) + 10);
    chk("R3 reached OFF", int'(cur_state), 0);

    // R6 wake by clock request
    tgt_state = 2'b11;
    expect_commit(2'b11, 2'b00, 1'b0);
    clk_req = 1'b1;
    tick(SETTLE + 10);
    clk_req = 1'b0;

    // R2 single step to ON-INACTIVE then hold
    tgt_state = 2'b10;
    expect_commit(2'b10, 2'b11, 1'b0);
    tick(SETTLE + 25);
    chk("R2 hold at inactive", int'(cur_state), 2);

    // R5 wake by service request from ON-INACTIVE
    expect_commit(2'b11, 2'b10, 1'b0);
    svc_req = 1'b1;
    tick(SETTLE + 10);
    tgt_state = 2'b11;
    tick(1);
    svc_req = 1'b0;
    tick(10);
    chk("R5 active after service wake", int'(cur_state), 3);
    chk("R3 all expected commits seen", exp_q.size(), 0);

    finish_run();
  end

endmodule